// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch stage and, for every fetched instruction, names the address to fetch next. The decoder hands it a small descriptor for the instruction at the fetch address: its kind (no branch, conditional branch, call or return) and its signed displacement. Conditional branches are looked up in a direct-mapped tagged table. Each entry holds a target and the last four resolved outcomes of that branch, and those four outcomes select one of sixteen 2-bit saturating counters that belong to the entry. The counter's upper bit gives the direction.

When the table has no entry for a conditional branch, a fixed rule stands in: branches that jump backward are taken and branches that jump forward fall through. The block reports a penalty of six cycles on such a guess. A taken dynamic prediction reports one bubble cycle before the target can be fetched. Calls push their return address onto an eight-deep circular stack, and returns pop it. Branch resolutions from the back end come in on a separate update port. They train the counters, shift the per-branch history and allocate entries on a miss.

Every prediction appears on registered outputs one clock after the fetch is presented.

Top module: `bp_fetch_predictor`

## Requirements
- R1: A valid fetch of kind 0 (kind codes: 0 = no branch, 1 = conditional, 2 = call, 3 = return) yields, on the next cycle, pred_valid = 1, pred_next = fetch_pc + 4, not taken, no bubble and zero penalty. An invalid fetch yields pred_valid = 0 with taken, bubble and penalty all zero.
- R2: A conditional fetch that misses the table (the entry at index fetch_pc[7:2] is invalid, or its tag differs from fetch_pc[15:8]) is predicted taken exactly when fetch_disp[15] is 1. A taken guess goes to fetch_pc + fetch_disp and a not-taken guess goes to fetch_pc + 4.
- R3: Every prediction made by the R2 rule reports pred_penalty = 6 and pred_bubble = 0. No other prediction reports a nonzero penalty.
- R4: A conditional fetch that hits the table reads the entry's counter selected by the entry's 4-bit history. The prediction is taken when that counter's bit 1 is set. Taken goes to the stored target with pred_bubble = 1. Not taken goes to fetch_pc + 4 with no bubble. The penalty is 0 in both cases.
- R5: A resolution that hits the table moves the counter at the entry's current history up by one (saturating at 3) when taken, and down by one (saturating at 0) when not taken. It then shifts the outcome into the history LSB and, when taken, replaces the stored target.
- R6: A resolution that misses the table allocates the entry with the resolved tag and target and a history of {000, outcome}. It leaves that entry's counters unchanged. An allocation evicts any other branch that shares the index.
- R7: A call fetch is predicted taken to fetch_pc + fetch_disp with pred_bubble = 1 and penalty 0, and pushes fetch_pc + 4 onto the return stack.
- R8: A return fetch pops the most recent pushed address and is predicted taken to it with pred_bubble = 1. When the stack is empty it is predicted not taken to fetch_pc + 4 with no bubble.
- R9: The return stack holds 8 addresses. A ninth push without a pop overwrites the oldest, so only the 8 newest remain poppable.
- R10: After reset, no prediction is valid, every table entry is invalid, every counter holds 1 (weakly not taken) and the return stack is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | 16 | Address of the fetched instruction |
| fetch_kind | input | 2 | Decoded branch kind: 0 none, 1 conditional, 2 call, 3 return |
| fetch_disp | input | 16 | Signed branch displacement from the descriptor |
| upd_valid | input | 1 | A conditional branch resolution is presented |
| upd_pc | input | 16 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 16 | Resolved target address |
| pred_valid | output | 1 | Registered prediction is valid |
| pred_next | output | 16 | Predicted next fetch address |
| pred_taken | output | 1 | Predicted direction is taken |
| pred_bubble | output | 1 | One bubble cycle before the target fetch |
| pred_penalty | output | 4 | Penalty cycles reported for a static guess |

## Verification
Plain sequential fetches and forward and backward conditional branches on a cold table separate the no-branch path from both arms of the static rule. Repeated taken resolutions on one address, followed by a short not-taken run, show the history walking through the counters and the dynamic prediction overruling a static guess that would disagree. A strictly alternating branch shows that different histories select different counters. An alias that shares an index but not a tag separates hit from miss and shows eviction. Nested calls and returns, an empty pop, and nine calls followed by nine returns cover stack order, underflow and the wrap on overflow.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_COND = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_t;
endpackage

// File: rtl/bp_dir_table.sv
// Direct-mapped tagged table: per-entry target, local history and a
// private bank of 2-bit counters selected by that history.
module bp_dir_table #(
  parameter int AW     = 16,
  parameter int OFFS   = 2,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-OFFS-1:0] lk_addr,
  output logic               lk_hit,
  output logic               lk_taken,
  output logic [AW-1:0]      lk_target,
  input  logic               up_valid,
  input  logic [AW-OFFS-1:0] up_addr,
  input  logic               up_taken,
  input  logic [AW-1:0]      up_target
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = AW - OFFS - IDX_W;
  localparam int PHT_W   = IDX_W + HIST_W;
  localparam int PHT_N   = 1 << PHT_W;

  logic              valid_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [AW-1:0]     tgt_q   [ENTRIES];
  logic [HIST_W-1:0] hist_q  [ENTRIES];
  logic [1:0]        cnt_q   [PHT_N];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             up_hit;
  logic [PHT_W-1:0] up_slot;
  logic [1:0]       up_cnt, up_cnt_nx;

  assign lk_idx    = lk_addr[IDX_W-1:0];
  assign lk_tag    = lk_addr[AW-OFFS-1:IDX_W];
  assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_taken  = cnt_q[{lk_idx, hist_q[lk_idx]}][1];
  assign lk_target = tgt_q[lk_idx];

  assign up_idx  = up_addr[IDX_W-1:0];
  assign up_tag  = up_addr[AW-OFFS-1:IDX_W];
  assign up_hit  = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign up_slot = {up_idx, hist_q[up_idx]};
  assign up_cnt  = cnt_q[up_slot];

  always_comb begin
    if (up_taken) up_cnt_nx = (up_cnt == 2'd3) ? 2'd3 : up_cnt + 2'd1;
    else          up_cnt_nx = (up_cnt == 2'd0) ? 2'd0 : up_cnt - 2'd1;
  end

  // Valid bits and counters need a known reset state.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
      for (int j = 0; j < PHT_N; j++)   cnt_q[j]   <= 2'd1;
    end else if (up_valid) begin
      if (up_hit) cnt_q[up_slot] <= up_cnt_nx;
      else        valid_q[up_idx] <= 1'b1;
    end
  end

  // Payload fields carry no reset so they map onto plain RAM.
  always_ff @(posedge clk) begin
    if (!rst && up_valid) begin
      if (up_hit) begin
        hist_q[up_idx] <= {hist_q[up_idx][HIST_W-2:0], up_taken};
        if (up_taken) tgt_q[up_idx] <= up_target;
      end else begin
        tag_q[up_idx]  <= up_tag;
        tgt_q[up_idx]  <= up_target;
        hist_q[up_idx] <= {{(HIST_W-1){1'b0}}, up_taken};
      end
    end
  end
endmodule

// File: rtl/bp_ras.sv
// Circular return-address stack; overflow overwrites the oldest slot.
module bp_ras #(
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] top,
  output logic          nonempty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] ptr_dn;

  assign ptr_dn   = ptr_q - PW'(1);
  assign top      = slot_q[ptr_dn];
  assign nonempty = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push) begin
      ptr_q <= ptr_q + PW'(1);
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + CW'(1);
    end else if (pop && nonempty) begin
      ptr_q <= ptr_dn;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && push) slot_q[ptr_q] <= push_addr;
  end
endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
  parameter int AW         = 16,
  parameter int OFFS       = 2,
  parameter int IDX_W      = 6,
  parameter int HIST_W     = 4,
  parameter int RAS_DEPTH  = 8,
  parameter int PEN_W      = 4,
  parameter int STATIC_PEN = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [AW-1:0]    fetch_pc,
  input  logic [1:0]       fetch_kind,
  input  logic [AW-1:0]    fetch_disp,
  input  logic             upd_valid,
  input  logic [AW-1:0]    upd_pc,
  input  logic             upd_taken,
  input  logic [AW-1:0]    upd_target,
  output logic             pred_valid,
  output logic [AW-1:0]    pred_next,
  output logic             pred_taken,
  output logic             pred_bubble,
  output logic [PEN_W-1:0] pred_penalty
);
  import bp_pkg::*;

  localparam logic [AW-1:0] INST_BYTES = AW'(1) << OFFS;

  br_kind_t      kind;
  logic [AW-1:0] seq_pc, rel_pc;
  logic          tb_hit, tb_taken;
  logic [AW-1:0] tb_target;
  logic          ras_push, ras_pop, ras_nonempty;
  logic [AW-1:0] ras_top;

  logic             nx_taken, nx_bubble;
  logic [AW-1:0]    nx_next;
  logic [PEN_W-1:0] nx_pen;

  assign kind   = br_kind_t'(fetch_kind);
  assign seq_pc = fetch_pc + INST_BYTES;
  assign rel_pc = fetch_pc + fetch_disp;

  bp_dir_table #(
    .AW(AW), .OFFS(OFFS), .IDX_W(IDX_W), .HIST_W(HIST_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .lk_addr   (fetch_pc[AW-1:OFFS]),
    .lk_hit    (tb_hit),
    .lk_taken  (tb_taken),
    .lk_target (tb_target),
    .up_valid  (upd_valid),
    .up_addr   (upd_pc[AW-1:OFFS]),
    .up_taken  (upd_taken),
    .up_target (upd_target)
  );

  assign ras_push = fetch_valid && (kind == BK_CALL);
  assign ras_pop  = fetch_valid && (kind == BK_RET);

  bp_ras #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
    .clk       (clk),
    .rst       (rst),
    .push      (ras_push),
    .push_addr (seq_pc),
    .pop       (ras_pop),
    .top       (ras_top),
    .nonempty  (ras_nonempty)
  );

  always_comb begin
    nx_next   = seq_pc;
    nx_taken  = 1'b0;
    nx_bubble = 1'b0;
    nx_pen    = '0;
    case (kind)
      BK_COND: begin
        if (tb_hit) begin
          if (tb_taken) begin
            nx_taken  = 1'b1;
            nx_bubble = 1'b1;
            nx_next   = tb_target;
          end
        end else begin
          nx_pen = PEN_W'(STATIC_PEN);
          if (fetch_disp[AW-1]) begin
            nx_taken = 1'b1;
            nx_next  = rel_pc;
          end
        end
      end
      BK_CALL: begin
        nx_taken  = 1'b1;
        nx_bubble = 1'b1;
        nx_next   = rel_pc;
      end
      BK_RET: begin
        if (ras_nonempty) begin
          nx_taken  = 1'b1;
          nx_bubble = 1'b1;
          nx_next   = ras_top;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid   <= 1'b0;
      pred_next    <= '0;
      pred_taken   <= 1'b0;
      pred_bubble  <= 1'b0;
      pred_penalty <= '0;
    end else begin
      pred_valid   <= fetch_valid;
      pred_next    <= fetch_valid ? nx_next : '0;
      pred_taken   <= fetch_valid && nx_taken;
      pred_bubble  <= fetch_valid && nx_bubble;
      pred_penalty <= fetch_valid ? nx_pen : '0;
    end
  end
endmodule

// File: rtl/bp_fetch_predictor_chk.sv
module bp_fetch_predictor_chk #(
  parameter int AW         = 16,
  parameter int OFFS       = 2,
  parameter int PEN_W      = 4,
  parameter int STATIC_PEN = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_valid,
  input logic [AW-1:0]    fetch_pc,
  input logic [1:0]       fetch_kind,
  input logic [AW-1:0]    fetch_disp,
  input logic             pred_valid,
  input logic [AW-1:0]    pred_next,
  input logic             pred_taken,
  input logic             pred_bubble,
  input logic [PEN_W-1:0] pred_penalty
);
  localparam logic [AW-1:0] STEP = AW'(1) << OFFS;

  // R1
  seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_kind == 2'd0) |=>
      (pred_valid && !pred_taken && !pred_bubble && pred_penalty == '0 &&
       pred_next == $past(fetch_pc) + STEP));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> (!pred_valid && !pred_taken && !pred_bubble && pred_penalty == '0));

  // R2
  fwd_static_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_kind == 2'd1 && !fetch_disp[AW-1]) |=>
      (pred_penalty == '0 || !pred_taken));

  // R3
  pen_value_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_penalty != '0) |-> (pred_penalty == PEN_W'(STATIC_PEN) && !pred_bubble));

  // R4
  bubble_taken_chk: assert property (@(posedge clk) disable iff (rst)
    pred_bubble |-> (pred_taken && pred_valid));

  // R7
  call_target_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_kind == 2'd2) |=>
      (pred_taken && pred_bubble && pred_penalty == '0 &&
       pred_next == $past(fetch_pc) + $past(fetch_disp)));
endmodule

bind bp_fetch_predictor bp_fetch_predictor_chk #(
  .AW(AW), .OFFS(OFFS), .PEN_W(PEN_W), .STATIC_PEN(STATIC_PEN)
) u_chk (.*);

// File: tb/bp_fetch_predictor_bench.sv
module bp_fetch_predictor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic [1:0]  fetch_kind = '0;
  logic [15:0] fetch_disp = '0;
  logic        upd_valid = 1'b0;
  logic [15:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [15:0] upd_target = '0;
  logic        pred_valid;
  logic [15:0] pred_next;
  logic        pred_taken;
  logic        pred_bubble;
  logic [3:0]  pred_penalty;

  always #10 clk = ~clk;

  bp_fetch_predictor u_bp_fetch_predictor (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [15:0] nxt;
    logic        tk;
    logic        bb;
    logic [3:0]  pen;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  // Reference model state
  logic        m_v   [64];
  logic [7:0]  m_tag [64];
  logic [15:0] m_tgt [64];
  logic [3:0]  m_hist[64];
  logic [1:0]  m_cnt [1024];
  logic [15:0] m_ras [8];
  int          m_rp, m_rc;

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    for (int i = 0; i < 1024; i++) m_cnt[i] = 2'd1;
    m_rp = 0;
    m_rc = 0;
  endtask

  task automatic do_fetch(input logic [15:0] pc, input logic [1:0] kind,
                          input logic [15:0] disp, input string req);
    exp_t e;
    int   idx;
    e.nxt = pc + 16'd4; e.tk = 1'b0; e.bb = 1'b0; e.pen = 4'd0;
    idx = int'(pc[7:2]);
    case (kind)
      2'd1: begin
        if (m_v[idx] && m_tag[idx] == pc[15:8]) begin
          if (m_cnt[idx*16 + int'(m_hist[idx])][1]) begin
            e.tk = 1'b1; e.bb = 1'b1; e.nxt = m_tgt[idx];
          end
        end else begin
          e.pen = 4'd6;
          if (disp[15]) begin e.tk = 1'b1; e.nxt = pc + disp; end
        end
      end
      2'd2: begin
        e.tk = 1'b1; e.bb = 1'b1; e.nxt = pc + disp;
        m_ras[m_rp] = pc + 16'd4;
        m_rp = (m_rp + 1) % 8;
        if (m_rc < 8) m_rc++;
      end
      2'd3: begin
        if (m_rc > 0) begin
          m_rp = (m_rp + 7) % 8;
          m_rc--;
          e.tk = 1'b1; e.bb = 1'b1; e.nxt = m_ras[m_rp];
        end
      end
      default: ;
    endcase
    @(negedge clk);
    upd_valid   = 1'b0;
    fetch_valid = 1'b1;
    fetch_pc    = pc;
    fetch_kind  = kind;
    fetch_disp  = disp;
    exp_q.push_back(e);
    tag_q.push_back(req);
  endtask

  task automatic do_update(input logic [15:0] pc, input logic tk,
                           input logic [15:0] tgt);
    int idx;
    int slot;
    idx = int'(pc[7:2]);
    if (m_v[idx] && m_tag[idx] == pc[15:8]) begin
      slot = idx*16 + int'(m_hist[idx]);
      if (tk && m_cnt[slot] != 2'd3) m_cnt[slot] = m_cnt[slot] + 2'd1;
      if (!tk && m_cnt[slot] != 2'd0) m_cnt[slot] = m_cnt[slot] - 2'd1;
      m_hist[idx] = {m_hist[idx][2:0], tk};
      if (tk) m_tgt[idx] = tgt;
    end else begin
      m_v[idx] = 1'b1; m_tag[idx] = pc[15:8]; m_tgt[idx] = tgt;
      m_hist[idx] = {3'b000, tk};
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    upd_valid   = 1'b1;
    upd_pc      = pc;
    upd_taken   = tk;
    upd_target  = tgt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetch_valid = 1'b0;
      upd_valid   = 1'b0;
    end
  endtask

  // Monitor: compare each produced prediction with the scoreboard
  always @(negedge clk) begin
    if (!rst && pred_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected prediction: next=%h expected none", pred_next);
      end else begin
        exp_t  e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        if (pred_next !== e.nxt || pred_taken !== e.tk ||
            pred_bubble !== e.bb || pred_penalty !== e.pen) begin
          bad++;
          $display("FAIL %s: next=%h tk=%b bb=%b pen=%0d expected next=%h tk=%b bb=%b pen=%0d",
                   r, pred_next, pred_taken, pred_bubble, pred_penalty,
                   e.nxt, e.tk, e.bb, e.pen);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: nothing valid out of reset
    total++;
    if (pred_valid !== 1'b0 || pred_taken !== 1'b0 || pred_penalty !== 4'd0) begin
      bad++;
      $display("FAIL R10: valid=%b tk=%b pen=%0d expected 0 0 0",
               pred_valid, pred_taken, pred_penalty);
    end

    // R1: sequential fetches
    do_fetch(16'h1000, 2'd0, 16'h0000, "R1");
    do_fetch(16'h2344, 2'd0, 16'h0040, "R1");
    // R2/R3 and R10 cold table: static forward and backward
    do_fetch(16'h0100, 2'd1, 16'h0040, "R2 R3 fwd");
    do_fetch(16'h0200, 2'd1, 16'hFFE0, "R2 R3 bwd");

    // R5/R6/R4: train one branch taken, forward displacement
    for (int i = 0; i < 8; i++) begin
      do_update(16'h0400, 1'b1, 16'h0300);
      do_fetch(16'h0400, 2'd1, 16'h0010, "R4 R5 R6 taken run");
    end
    for (int i = 0; i < 3; i++) begin
      do_update(16'h0400, 1'b0, 16'h0300);
      do_fetch(16'h0400, 2'd1, 16'h0010, "R4 R5 not-taken run");
    end

    // R4: alternating branch, histories select separate counters
    for (int i = 0; i < 14; i++) begin
      do_update(16'h0800, (i % 2) == 0, 16'h0900);
      do_fetch(16'h0800, 2'd1, 16'hFF00, "R4 R5 alternating");
    end

    // R2: alias with same index, different tag misses
    do_fetch(16'h0500, 2'd1, 16'hFFF0, "R2 tag mismatch");
    // R6: allocation evicts the old branch
    do_update(16'h0500, 1'b0, 16'h0600);
    do_fetch(16'h0400, 2'd1, 16'h0010, "R6 evicted");
    do_fetch(16'h0500, 2'd1, 16'hFFF0, "R6 allocated hit");

    // R7/R8: nested calls, returns, empty pop
    do_fetch(16'h1000, 2'd2, 16'h0200, "R7 call");
    do_fetch(16'h1200, 2'd2, 16'h0100, "R7 nested call");
    do_fetch(16'h1300, 2'd3, 16'h0000, "R8 return inner");
    do_fetch(16'h1210, 2'd3, 16'h0000, "R8 return outer");
    do_fetch(16'h1020, 2'd3, 16'h0000, "R8 empty pop");

    // R9: nine calls then nine returns
    for (int i = 0; i < 9; i++)
      do_fetch(16'h2000 + 16'(i*16), 2'd2, 16'h0100, "R9 push");
    for (int i = 0; i < 9; i++)
      do_fetch(16'h3000 + 16'(i*4), 2'd3, 16'h0000, "R9 pop");

    idle(4);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1: pending=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule